// File: doc/BRIEF.md
# Multi-buffer DMA channel status flags

This block keeps the bookkeeping for a DMA channel whose storage is split into `NBUF` equal buffers used in ring order. One side of the channel is an external parallel port and the other is an internal packet engine. Depending on `dir_i`, the external side is either the producer or the consumer. Each buffer moves through four states: empty, filling, full and draining. The producer only ever touches an empty or filling buffer, and the consumer only ever touches a full or draining one. This lets both sides work at once on different buffers. Each beat moves one byte. A buffer is complete after `BUF_BYTES` beats, and `BUF_BYTES` is a whole multiple of `PKT_BYTES`.

Two flags go to the external side. The first is a stall flag. It looks at the whole ring, not only the buffer in use, and it is asserted when the external side can make no progress. With the external side writing, that means every buffer is full. With the external side reading, it means no buffer holds completed data. The second is a watermark flag. It compares the byte position in the external side's current buffer against a programmable level, to give early notice of a buffer end.

Both flags pass through a fixed register pipeline and have selectable polarity. Right after the external side finishes a buffer there is a switch-over window. During that window the watermark is forced inactive and a separate valid output is low. External logic should therefore start transfers from the stall flag only.

Top module: `dma_ring_flags`

## Requirements
- R1: With a full buffer waiting, the producer can fill an empty buffer while the consumer drains the full one, in the same cycles. Both sides make progress.
- R2: With `dir_i`=0 (external writes), the logical stall flag asserts only when all `NBUF` buffers are full. It is released once one buffer has been completely drained; a partial drain does not release it.
- R3: With `dir_i`=1 (external reads), the logical stall flag is asserted whenever no buffer holds completed data, and released once one buffer is complete.
- R4: With `dir_i`=0, an external write while every buffer is full is dropped and does not count toward any buffer. The same write sets `ovf_o`, which stays at 1 until reset.
- R5: With `dir_i`=0, the logical watermark is 1 when the byte count already written into the current external buffer is at least `wm_level_i`.
- R6: With `dir_i`=1, the logical watermark is 1 when the bytes still unread in the current external buffer number at most `wm_level_i`.
- R7: When the external side finishes a buffer, raw valid is low for `SW_CYC` cycles and the logical watermark is forced to 0. After the flag delay, this shows as `wm_valid_o`=0 and `wm_o` at its inactive level.
- R8: A change in the stall state reaches `stall_o` exactly `FLAG_DLY` (default 2) clock edges after the edge that caused it.
- R9: `rdy_pol_i`=1 gives an active-high `stall_o` and `rdy_pol_i`=0 gives an active-low one. `wm_pol_i` sets the polarity of `wm_o` in the same way. Polarity changes the pin level only, never the logical meaning.
- R10: While in reset, the logical stall flag is asserted, the logical watermark is 0, `wm_valid_o`=0 and `ovf_o`=0. With `dir_i`=0 and an empty ring, the stall flag is released `FLAG_DLY` edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 0: external side writes; 1: external side reads. Held stable outside reset |
| rdy_pol_i | input | 1 | Polarity of `stall_o`: 1 active high, 0 active low |
| wm_pol_i | input | 1 | Polarity of `wm_o`: 1 active high, 0 active low |
| wm_level_i | input | $clog2(BUF_BYTES+1) | Watermark level in bytes |
| ext_beat_i | input | 1 | External side moves one byte this cycle |
| int_beat_i | input | 1 | Internal side moves one byte this cycle |
| stall_o | output | 1 | Ring-wide "cannot proceed" flag, delayed and polarity applied |
| wm_o | output | 1 | Watermark flag, delayed and polarity applied |
| wm_valid_o | output | 1 | Low while the watermark is undefined (buffer switch-over) |
| ovf_o | output | 1 | Sticky dropped-write indicator |

## Verification
Some properties are checked on every cycle. The producer and consumer never accept a beat on the same buffer. A full or empty ring always has both pointers on the same buffer. A dropped external write always raises the sticky overflow, and it never clears. A rising or falling stall state is not visible at the output one edge later. A buffer completion on the external side always drops the raw watermark valid. A few things only the bench scenarios can show. These are the full ring-wide sequence of stall assertion and release, including partial drains and overlapped fill and drain. They also include the exact byte at which the watermark turns on in each direction, the length of the switch-over window at the pins, and proof that dropped writes leave the fill count untouched.

// File: rtl/dma_ring_pkg.sv
`timescale 1ns/1ps
package dma_ring_pkg;
  typedef enum logic [1:0] {
    BUF_EMPTY = 2'd0,
    BUF_FILL  = 2'd1,
    BUF_FULL  = 2'd2,
    BUF_DRAIN = 2'd3
  } buf_state_e;
endpackage

// File: rtl/dma_beat_counter.sv
`timescale 1ns/1ps
module dma_beat_counter #(
  parameter int BUF_BYTES = 16,
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] LAST = CW'(BUF_BYTES - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = beat_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (beat_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_in_buf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/dma_ring_tracker.sv
`timescale 1ns/1ps
module dma_ring_tracker
  import dma_ring_pkg::*;
#(
  parameter int NBUF = 4,
  localparam int PW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prod_req_i,
  input  logic cons_req_i,
  input  logic prod_wrap_i,
  input  logic cons_wrap_i,
  output logic prod_acc_o,
  output logic cons_acc_o,
  output logic any_free_o,
  output logic any_ready_o
);
  localparam logic [PW-1:0] PTR_LAST = PW'(NBUF - 1);

  buf_state_e      st_q [NBUF];
  logic [NBUF-1:0] writable, readable;
  logic [PW-1:0]   prod_ptr_q, cons_ptr_q;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    assign writable[b] = (st_q[b] == BUF_EMPTY) || (st_q[b] == BUF_FILL);
    assign readable[b] = (st_q[b] == BUF_FULL)  || (st_q[b] == BUF_DRAIN);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        st_q[b] <= BUF_EMPTY;
      else if (prod_acc_o && prod_ptr_q == PW'(b))
        st_q[b] <= prod_wrap_i ? BUF_FULL : BUF_FILL;
      else if (cons_acc_o && cons_ptr_q == PW'(b))
        st_q[b] <= cons_wrap_i ? BUF_EMPTY : BUF_DRAIN;
    end
  end

  // Ring order keeps the pointed buffer representative of the whole ring.
  assign prod_acc_o  = prod_req_i && writable[prod_ptr_q];
  assign cons_acc_o  = cons_req_i && readable[cons_ptr_q];
  assign any_free_o  = |writable;
  assign any_ready_o = |readable;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_ptr_q <= '0;
      cons_ptr_q <= '0;
    end else begin
      if (prod_wrap_i) prod_ptr_q <= (prod_ptr_q == PTR_LAST) ? '0 : prod_ptr_q + 1'b1;
      if (cons_wrap_i) cons_ptr_q <= (cons_ptr_q == PTR_LAST) ? '0 : cons_ptr_q + 1'b1;
    end
  end

  assert_disjoint_bufs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_acc_o && cons_acc_o) |-> (prod_ptr_q != cons_ptr_q));
  assert_full_ring_ptrs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_free_o |-> (prod_ptr_q == cons_ptr_q));
  assert_empty_ring_ptrs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_ready_o |-> (prod_ptr_q == cons_ptr_q));
endmodule

// File: rtl/dma_flag_pipe.sv
`timescale 1ns/1ps
module dma_flag_pipe #(
  parameter int W   = 3,
  parameter int DLY = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DLY];

  for (genvar s = 0; s < DLY; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[DLY-1];
endmodule

// File: rtl/dma_ring_flags.sv
`timescale 1ns/1ps
module dma_ring_flags #(
  parameter int NBUF      = 4,
  parameter int PKT_BYTES = 8,
  parameter int BUF_PKTS  = 2,
  parameter int FLAG_DLY  = 2,
  parameter int SW_CYC    = 2,
  localparam int BUF_BYTES = PKT_BYTES * BUF_PKTS,
  localparam int CW  = $clog2(BUF_BYTES + 1),
  localparam int SWW = $clog2(SW_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_i,
  input  logic          rdy_pol_i,
  input  logic          wm_pol_i,
  input  logic [CW-1:0] wm_level_i,
  input  logic          ext_beat_i,
  input  logic          int_beat_i,
  output logic          stall_o,
  output logic          wm_o,
  output logic          wm_valid_o,
  output logic          ovf_o
);
  logic prod_req, cons_req, prod_acc, cons_acc, prod_wrap, cons_wrap;
  logic any_free, any_ready;
  logic [CW-1:0] fill_cnt, drain_cnt;

  // dir_i=0: external produces; dir_i=1: external consumes
  assign prod_req = dir_i ? int_beat_i : ext_beat_i;
  assign cons_req = dir_i ? ext_beat_i : int_beat_i;

  dma_ring_tracker #(.NBUF(NBUF)) u_ring (
    .clk_i, .rst_ni,
    .prod_req_i (prod_req),
    .cons_req_i (cons_req),
    .prod_wrap_i(prod_wrap),
    .cons_wrap_i(cons_wrap),
    .prod_acc_o (prod_acc),
    .cons_acc_o (cons_acc),
    .any_free_o (any_free),
    .any_ready_o(any_ready)
  );

  dma_beat_counter #(.BUF_BYTES(BUF_BYTES)) u_fill (
    .clk_i, .rst_ni, .beat_i(prod_acc), .cnt_o(fill_cnt), .wrap_o(prod_wrap)
  );

  dma_beat_counter #(.BUF_BYTES(BUF_BYTES)) u_drain (
    .clk_i, .rst_ni, .beat_i(cons_acc), .cnt_o(drain_cnt), .wrap_o(cons_wrap)
  );

  logic ext_wrap, stall_raw, wm_cmp, wm_raw, wm_valid_raw;
  logic [CW-1:0]  left_cnt;
  logic [SWW-1:0] sw_q;
  logic           ovf_q;

  assign ext_wrap  = dir_i ? cons_wrap : prod_wrap;
  assign stall_raw = dir_i ? !any_ready : !any_free;
  assign left_cnt  = CW'(BUF_BYTES) - drain_cnt;
  assign wm_cmp    = dir_i ? (left_cnt <= wm_level_i) : (fill_cnt >= wm_level_i);

  // switch-over window: watermark undefined, held inactive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sw_q <= '0;
    else if (ext_wrap)    sw_q <= SWW'(SW_CYC);
    else if (sw_q != '0)  sw_q <= sw_q - 1'b1;
  end

  assign wm_valid_raw = (sw_q == '0);
  assign wm_raw       = wm_valid_raw && wm_cmp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  ovf_q <= 1'b0;
    else if (!dir_i && ext_beat_i && !any_free)   ovf_q <= 1'b1;
  end

  logic stall_d, wm_d, wm_valid_d;

  dma_flag_pipe #(.W(3), .DLY(FLAG_DLY), .RST_VAL(3'b100)) u_pipe (
    .clk_i, .rst_ni,
    .d_i({stall_raw, wm_raw, wm_valid_raw}),
    .q_o({stall_d, wm_d, wm_valid_d})
  );

  assign stall_o    = stall_d ^ ~rdy_pol_i;
  assign wm_o       = wm_d ^ ~wm_pol_i;
  assign wm_valid_o = wm_valid_d;
  assign ovf_o      = ovf_q;

  assert_no_early_stall_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_raw) |=> !stall_d);
  assert_no_early_stall_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_raw) |=> stall_d);
  assert_switch_drops_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wrap |=> !wm_valid_raw);
  assert_wm_inactive_when_invalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wm_valid_o |-> (wm_o == !wm_pol_i));
  assert_drop_sets_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && ext_beat_i && stall_raw) |=> ovf_o);
  assert_ovf_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: tb/dma_ring_flags_bench.sv
`timescale 1ns/1ps
module dma_ring_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir = 1'b0, rdy_pol = 1'b1, wm_pol = 1'b1;
  logic [4:0] wm_level = 5'd31;
  logic ext_beat = 1'b0, int_beat = 1'b0;
  logic stall, wm, wm_valid, ovf;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_ring_flags u_dma_ring_flags (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .rdy_pol_i(rdy_pol), .wm_pol_i(wm_pol),
    .wm_level_i(wm_level), .ext_beat_i(ext_beat), .int_beat_i(int_beat),
    .stall_o(stall), .wm_o(wm), .wm_valid_o(wm_valid), .ovf_o(ovf)
  );

  // {ext, int, beats[7:0], expected logical stall}; external writes, 4 x 16-byte buffers
  localparam logic [10:0] VEC [9] = '{
    {1'b1, 1'b0, 8'd16, 1'b0},
    {1'b1, 1'b0, 8'd32, 1'b0},
    {1'b1, 1'b0, 8'd16, 1'b1},
    {1'b0, 1'b1, 8'd8,  1'b1},
    {1'b0, 1'b1, 8'd8,  1'b0},
    {1'b1, 1'b1, 8'd16, 1'b0},
    {1'b1, 1'b0, 8'd16, 1'b1},
    {1'b0, 1'b1, 8'd64, 1'b0},
    {1'b1, 1'b0, 8'd64, 1'b1}
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic run(input logic e, input logic i, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ext_beat = e; int_beat = i;
    end
    @(negedge clk); ext_beat = 1'b0; int_beat = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic d);
    @(negedge clk);
    rst_n = 1'b0; dir = d; ext_beat = 1'b0; int_beat = 1'b0;
    rdy_pol = 1'b1; wm_pol = 1'b1;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  initial begin
    // R10: reset state
    do_reset(1'b0);
    rst_n = 1'b0;
    wait_n(1);
    chk("R10 stall in reset", stall, 1'b1);
    chk("R10 wm in reset", wm, 1'b0);
    chk("R10 valid in reset", wm_valid, 1'b0);
    chk("R10 ovf in reset", ovf, 1'b0);
    rst_n = 1'b1;
    wait_n(1);
    chk("R10 stall one edge after release", stall, 1'b1);
    wait_n(1);
    chk("R10 stall released after two edges", stall, 1'b0);

    // R1/R2 table
    wm_level = 5'd31;
    for (int v = 0; v < 9; v++) begin
      run(VEC[v][10], VEC[v][9], int'(VEC[v][8:1]));
      wait_n(3);
      chk((v == 5 || v == 6) ? "R1 overlapped fill/drain vector" : "R2 ring-wide stall vector",
          stall, VEC[v][0]);
    end

    // R9: polarity (ring is full here, watermark logically 0)
    wait_n(5);
    rdy_pol = 1'b0; wm_pol = 1'b0;
    #1;
    chk("R9 active-low stall pin", stall, 1'b0);
    chk("R9 active-low wm pin", wm, 1'b1);
    rdy_pol = 1'b1; wm_pol = 1'b1;

    // R8: exact latency of stall rise
    do_reset(1'b0);
    wait_n(2);
    run(1'b1, 1'b0, 63);
    wait_n(3);
    chk("R8 stall idle before last byte", stall, 1'b0);
    run(1'b1, 1'b0, 1);
    chk("R8 stall not at edge+0", stall, 1'b0);
    wait_n(1);
    chk("R8 stall not at edge+1", stall, 1'b0);
    wait_n(1);
    chk("R8 stall at edge+2", stall, 1'b1);

    // R4: dropped writes, sticky overflow
    chk("R4 no overflow yet", ovf, 1'b0);
    run(1'b1, 1'b0, 3);
    chk("R4 overflow set by dropped write", ovf, 1'b1);
    run(1'b0, 1'b1, 16);
    wait_n(3);
    chk("R4 one buffer freed", stall, 1'b0);
    chk("R4 overflow sticky", ovf, 1'b1);
    wm_level = 5'd1;
    wait_n(3);
    chk("R4 dropped bytes not counted", wm, 1'b0);
    run(1'b1, 1'b0, 1);
    wait_n(3);
    chk("R4 accepted byte counted", wm, 1'b1);

    // R5/R7: external-write watermark and switch-over window
    do_reset(1'b0);
    wm_level = 5'd12;
    wait_n(2);
    run(1'b1, 1'b0, 11);
    wait_n(3);
    chk("R5 wm off at 11 bytes", wm, 1'b0);
    chk("R5 valid outside switch", wm_valid, 1'b1);
    run(1'b1, 1'b0, 1);
    wait_n(3);
    chk("R5 wm on at 12 bytes", wm, 1'b1);
    run(1'b1, 1'b0, 3);
    run(1'b1, 1'b0, 1);
    wait_n(2);
    chk("R7 valid low in switch window", wm_valid, 1'b0);
    chk("R7 wm inactive in switch window", wm, 1'b0);
    wait_n(3);
    chk("R7 valid back after window", wm_valid, 1'b1);
    chk("R7 wm reflects new empty buffer", wm, 1'b0);

    // R3/R6: external-read direction
    do_reset(1'b1);
    wait_n(4);
    chk("R3 stall asserted with nothing committed", stall, 1'b1);
    run(1'b0, 1'b1, 16);
    wait_n(3);
    chk("R3 stall released by committed buffer", stall, 1'b0);
    wm_level = 5'd4;
    run(1'b1, 1'b0, 11);
    wait_n(3);
    chk("R6 wm off with 5 bytes left", wm, 1'b0);
    run(1'b1, 1'b0, 1);
    wait_n(3);
    chk("R6 wm on with 4 bytes left", wm, 1'b1);
    run(1'b1, 1'b0, 4);
    wait_n(3);
    chk("R3 stall back when ring drained", stall, 1'b1);
    chk("R4 no overflow on reads", ovf, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog (all requirements) got hang exp finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule